// File: doc/BRIEF.md
# Warp Lane-Mask Divergence Sequencer

This unit holds the active-lane mask of one warp and steps it through two-way conditional branches. All active lanes execute the same instruction in lockstep, so when a branch condition differs across the active lanes, the two sides of the branch must run one after the other. For each issued branch the unit forms two candidate masks: active lanes whose condition bit is set, and active lanes whose condition bit is clear. If both are non-empty the branch has diverged. The unit then presents the taken-side mask for a first pass, then the not-taken-side mask for a second pass. At the reconvergence point it restores the mask that was live before the branch. If every active lane agrees, the empty side is skipped and the branch costs one pass with the mask unchanged.

Divergent branches may nest. Each one saves its pre-branch mask, its deferred not-taken mask and the state to return to on a reconvergence stack of fixed depth. A branch issued while that stack is full is dropped and sets a sticky overflow flag. A running total of executed passes lets the cost of a code region be compared with its expected divergence cost.

The controller has three states:
- `ST_CONVERGED`: no divergent branch is outstanding.
- `ST_TAKEN`: the innermost divergent branch is in its first pass.
- `ST_NOT_TAKEN`: the innermost divergent branch is in its second pass.

It has these transitions:
- **diverge**: any state goes to `ST_TAKEN` when a branch with both sides non-empty is accepted.
- **switch**: `ST_TAKEN` goes to `ST_NOT_TAKEN` on pass-done.
- **reconverge**: `ST_NOT_TAKEN` returns to the state saved with the stack entry on pass-done.
- **hold**: the state stays as it is on a uniform branch, a dropped branch, or a pass-done while converged.

Top module: `warp_diverge_ctl`

## Requirements
- R1: After reset the lane mask is all ones, the nesting depth is 0, the path indicator is 1, the overflow flag is 0, the pass count is 0, and the branch-ready output is 1.
- R2: A branch accepted while all active lanes agree leaves the mask and the depth unchanged and adds 1 to the pass count on the next cycle.
- R3: A divergent branch accepted at a clock edge makes the mask equal to (pre-branch mask AND condition) after that edge. It also sets the path indicator to 1 (taken), increases the depth by 1, and adds 1 to the pass count.
- R4: Pass-done during a first pass makes the mask equal to (pre-branch mask AND NOT condition), sets the path indicator to 0 (not taken), and adds 1 to the pass count.
- R5: Pass-done during a second pass restores the pre-branch mask, decreases the depth by 1, and returns the path indicator to the value of the enclosing level (1 at depth 0), with the pass count unchanged.
- R6: Condition bits of inactive lanes have no effect: a lane outside the mask never becomes active, and a branch whose active lanes agree stays uniform whatever the inactive lanes carry.
- R7: Cost does not depend on lane pattern: a branch with alternating even/odd condition bits adds exactly 2 to the pass count over its lifetime.
- R8: Divergent branches nest to a depth of 4. Any branch accepted at depth 4 sets the overflow flag, which then stays set, and leaves the mask, the depth and the pass count unchanged.
- R9: Pass-done while no divergent branch is outstanding (depth 0) has no effect on any output.
- R10: Branch-ready is low in exactly the cycles where pass-done is high. A branch offered in such a cycle is not accepted, and the pass-done takes effect.
- R11: The pass count increases by at most 1 per cycle and equals the total number of passes started since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | Branch offered |
| br_ready_o | output | 1 | Branch can be accepted this cycle |
| br_cond_i | input | LANES | Per-lane branch condition |
| pass_done_i | input | 1 | Datapath finished the current pass |
| lane_mask_o | output | LANES | Lanes enabled for the current pass |
| path_taken_o | output | 1 | 1 on taken side or converged, 0 on not-taken side |
| nest_depth_o | output | clog2(DEPTH+1) | Reconvergence stack occupancy |
| ovf_err_o | output | 1 | Sticky stack-overflow flag |
| pass_count_o | output | CNT_W | Passes started since reset |

## Verification
Every result is registered once, so the effect of a branch or pass-done presented before a rising edge shows on the outputs right after that edge; branch-ready alone is combinational and is due in the same cycle as pass-done. The bench drives inputs on the falling edge and checks ready shortly after. It then advances a behavioural model of the masks and stack at the rising edge and compares every output at the next falling edge. Directed checks on the pass count span a whole branch, so the two-pass cost is confirmed across the switch and the reconverge.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    typedef enum logic [1:0] {
        ST_CONVERGED = 2'd0,
        ST_TAKEN     = 2'd1,
        ST_NOT_TAKEN = 2'd2
    } wdiv_state_e;

endpackage

// File: rtl/wdiv_split.sv
// Splits the active mask into the two branch sides and flags divergence.
module wdiv_split #(
    parameter int unsigned LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] cond_i,
    output logic [LANES-1:0] tk_o,
    output logic [LANES-1:0] nt_o,
    output logic             split_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tk_o[g] = mask_i[g] & cond_i[g];
        assign nt_o[g] = mask_i[g] & ~cond_i[g];
    end

    assign split_o = (|tk_o) & (|nt_o);

endmodule

// File: rtl/wdiv_stack.sv
// Reconvergence stack: saved pre-branch mask, deferred mask, return state.
module wdiv_stack #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [LANES-1:0]           push_pre_i,
    input  logic [LANES-1:0]           push_alt_i,
    input  logic [1:0]                 push_ret_i,
    output logic [LANES-1:0]           top_pre_o,
    output logic [LANES-1:0]           top_alt_o,
    output logic [1:0]                 top_ret_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       full_o,
    output logic                       empty_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0] pre_q [DEPTH];
    logic [LANES-1:0] alt_q [DEPTH];
    logic [1:0]       ret_q [DEPTH];
    logic [PTR_W-1:0] depth_q;
    logic [PTR_W-1:0] below;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign below   = depth_q - 1'b1;
    assign top_idx = below[IDX_W-1:0];
    assign wr_idx  = depth_q[IDX_W-1:0];
    assign full_o  = (depth_q == PTR_W'(DEPTH));
    assign empty_o = (depth_q == '0);
    assign depth_o = depth_q;

    assign top_pre_o = pre_q[top_idx];
    assign top_alt_o = alt_q[top_idx];
    assign top_ret_o = ret_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push_i && !full_o) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !full_o) begin
            pre_q[wr_idx] <= push_pre_i;
            alt_q[wr_idx] <= push_alt_i;
            ret_q[wr_idx] <= push_ret_i;
        end
    end

    // R8
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R5
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    // R8
    no_simultaneous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/warp_diverge_ctl.sv
module warp_diverge_ctl
    import wdiv_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       br_valid_i,
    output logic                       br_ready_o,
    input  logic [LANES-1:0]           br_cond_i,
    input  logic                       pass_done_i,
    output logic [LANES-1:0]           lane_mask_o,
    output logic                       path_taken_o,
    output logic [$clog2(DEPTH+1)-1:0] nest_depth_o,
    output logic                       ovf_err_o,
    output logic [CNT_W-1:0]           pass_count_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH + 1);

    wdiv_state_e      state_q, state_d;
    logic [LANES-1:0] mask_q, mask_d;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q, err_d;
    logic             cnt_inc;
    logic             push, pop;
    logic             br_fire;

    logic [LANES-1:0] tk_mask, nt_mask;
    logic             split;
    logic [LANES-1:0] top_pre, top_alt;
    logic [1:0]       top_ret;
    logic [PTR_W-1:0] depth;
    logic             full, empty;

    wdiv_split #(.LANES(LANES)) split_i (
        .mask_i  (mask_q),
        .cond_i  (br_cond_i),
        .tk_o    (tk_mask),
        .nt_o    (nt_mask),
        .split_o (split)
    );

    wdiv_stack #(.LANES(LANES), .DEPTH(DEPTH)) stack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_pre_i (mask_q),
        .push_alt_i (nt_mask),
        .push_ret_i (state_q),
        .top_pre_o  (top_pre),
        .top_alt_o  (top_alt),
        .top_ret_o  (top_ret),
        .depth_o    (depth),
        .full_o     (full),
        .empty_o    (empty)
    );

    assign br_ready_o = !pass_done_i;
    assign br_fire    = br_valid_i && br_ready_o;

    // Next-state and stack control
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        err_d   = err_q;
        cnt_inc = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        if (pass_done_i) begin
            unique case (state_q)
                ST_CONVERGED: ;
                ST_TAKEN: begin
                    mask_d  = top_alt;
                    state_d = ST_NOT_TAKEN;
                    cnt_inc = 1'b1;
                end
                ST_NOT_TAKEN: begin
                    mask_d  = top_pre;
                    state_d = wdiv_state_e'(top_ret);
                    pop     = 1'b1;
                end
                default: ;
            endcase
        end else if (br_fire) begin
            if (full) begin
                err_d = 1'b1;
            end else if (split) begin
                push    = 1'b1;
                mask_d  = tk_mask;
                state_d = ST_TAKEN;
                cnt_inc = 1'b1;
            end else begin
                cnt_inc = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CONVERGED;
            mask_q  <= '1;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            err_q   <= err_d;
            cnt_q   <= cnt_q + CNT_W'(cnt_inc);
        end
    end

    // Outputs
    always_comb begin
        lane_mask_o  = mask_q;
        path_taken_o = (state_q != ST_NOT_TAKEN);
        nest_depth_o = depth;
        ovf_err_o    = err_q;
        pass_count_o = cnt_q;
    end

    // R3
    narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fire && !full) |=> ((lane_mask_o & ~$past(lane_mask_o)) == '0));

    // R4
    switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKEN && pass_done_i) |=>
            (!path_taken_o && ((lane_mask_o & $past(lane_mask_o)) == '0)));

    // R5
    reconverge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOT_TAKEN && pass_done_i) |=>
            (nest_depth_o == ($past(nest_depth_o) - 1'b1)));

    // R5
    converged_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERGED) == empty);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fire && full) |=>
            (ovf_err_o && $stable(lane_mask_o) && $stable(nest_depth_o)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERGED && pass_done_i) |=>
            ($stable(lane_mask_o) && $stable(pass_count_o)));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pass_count_o == $past(pass_count_o)) ||
                  (pass_count_o == ($past(pass_count_o) + 1'b1))));

    // R6
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask_o != '0);

endmodule

// File: tb/warp_diverge_ctl_tb_top.sv
module warp_diverge_ctl_tb_top;

    localparam int L = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic          br_ready;
    logic [L-1:0]  br_cond = '0;
    logic          pass_done = 1'b0;
    logic [L-1:0]  lane_mask;
    logic          path_taken;
    logic [2:0]    nest_depth;
    logic          ovf_err;
    logic [31:0]   pass_count;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    logic [L-1:0] m_mask = '1;
    bit           m_second = 0;
    bit           m_err = 0;
    int           m_cnt = 0;
    logic [L-1:0] pre_q[$];
    logic [L-1:0] alt_q[$];
    bit           ret_q[$];

    warp_diverge_ctl #(.LANES(L), .DEPTH(4), .CNT_W(32)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_valid_i   (br_valid),
        .br_ready_o   (br_ready),
        .br_cond_i    (br_cond),
        .pass_done_i  (pass_done),
        .lane_mask_o  (lane_mask),
        .path_taken_o (path_taken),
        .nest_depth_o (nest_depth),
        .ovf_err_o    (ovf_err),
        .pass_count_o (pass_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update(input bit v, input logic [L-1:0] c, input bit d);
        logic [L-1:0] t, n;
        if (d) begin
            if (pre_q.size() > 0) begin
                if (!m_second) begin
                    m_mask = alt_q[$];
                    m_second = 1;
                    m_cnt++;
                end else begin
                    m_mask = pre_q[$];
                    m_second = ret_q[$];
                    void'(pre_q.pop_back());
                    void'(alt_q.pop_back());
                    void'(ret_q.pop_back());
                end
            end
        end else if (v) begin
            if (pre_q.size() == 4) begin
                m_err = 1;
            end else begin
                t = m_mask & c;
                n = m_mask & ~c;
                if (t != 0 && n != 0) begin
                    pre_q.push_back(m_mask);
                    alt_q.push_back(n);
                    ret_q.push_back(m_second);
                    m_mask = t;
                    m_second = 0;
                end
                m_cnt++;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "mask", 64'(lane_mask), 64'(m_mask));
        chk(tag, "path", 64'(path_taken), 64'(pre_q.size() == 0 ? 1'b1 : !m_second));
        chk(tag, "depth", 64'(nest_depth), 64'(pre_q.size()));
        chk(tag, "ovf", 64'(ovf_err), 64'(m_err));
        chk(tag, "count", 64'(pass_count), 64'(m_cnt));
    endtask

    // Called at a falling edge: drive, check ready, clock, compare.
    task automatic step(input bit v, input logic [L-1:0] c, input bit d, input string tag);
        br_valid = v;
        br_cond = c;
        pass_done = d;
        #1;
        chk("R10", "ready", 64'(br_ready), 64'(!d));
        @(posedge clk);
        model_update(v, c, d);
        @(negedge clk);
        compare_all(tag);
        br_valid = 0;
        pass_done = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mask", 64'(lane_mask), 64'hFFFF_FFFF);
        chk("R1", "depth", 64'(nest_depth), 0);
        chk("R1", "path", 64'(path_taken), 1);
        chk("R1", "ovf", 64'(ovf_err), 0);
        chk("R1", "count", 64'(pass_count), 0);
        chk("R1", "ready", 64'(br_ready), 1);

        // R2 uniform branches
        step(1, 32'hFFFF_FFFF, 0, "R2");
        step(1, 32'h0000_0000, 0, "R2");
        chk("R2", "count literal", 64'(pass_count), 2);

        // R9 idle pass-done
        step(0, '0, 1, "R9");
        step(0, '0, 0, "R9");

        // R3 / R4 / R5 single divergent branch
        step(1, 32'h0000_FFFF, 0, "R3");
        chk("R3", "mask literal", 64'(lane_mask), 64'h0000_FFFF);
        step(0, '0, 1, "R4");
        chk("R4", "mask literal", 64'(lane_mask), 64'hFFFF_0000);
        chk("R4", "path literal", 64'(path_taken), 0);
        step(0, '0, 1, "R5");
        chk("R5", "mask literal", 64'(lane_mask), 64'hFFFF_FFFF);

        // R7 alternating lanes cost exactly two passes
        c0 = pass_count;
        step(1, 32'h5555_5555, 0, "R7");
        step(0, '0, 0, "R7");
        step(0, '0, 1, "R7");
        step(0, '0, 1, "R7");
        chk("R7", "pass delta", 64'(pass_count - c0), 2);

        // Nesting to depth 4
        step(1, 32'h0F0F_0F0F, 0, "R3");
        step(1, 32'h00FF_00FF, 0, "R3");
        // R6 inactive lanes differ but active lanes agree -> uniform
        step(1, 32'hF0F0_F0F0 | 32'h000F_000F, 0, "R6");
        chk("R6", "depth literal", 64'(nest_depth), 2);
        chk("R6", "mask literal", 64'(lane_mask), 64'h000F_000F);
        step(1, 32'h0003_0003, 0, "R3");
        step(1, 32'h0001_0001, 0, "R3");
        chk("R8", "depth at limit", 64'(nest_depth), 4);
        // R8 overflow
        c0 = pass_count;
        step(1, 32'h0000_0001, 0, "R8");
        chk("R8", "ovf literal", 64'(ovf_err), 1);
        chk("R8", "count unchanged", 64'(pass_count - c0), 0);
        step(1, 32'hFFFF_FFFF, 0, "R8");

        // R10 branch offered with pass-done: pass-done wins
        step(1, 32'h0000_0001, 1, "R10");
        step(0, '0, 1, "R5");
        for (int i = 0; i < 6; i++) step(0, '0, 1, "R5");
        chk("R5", "final mask", 64'(lane_mask), 64'hFFFF_FFFF);
        chk("R5", "final depth", 64'(nest_depth), 0);
        chk("R8", "ovf sticky", 64'(ovf_err), 1);
        step(0, '0, 1, "R9");
        chk("R11", "total passes", 64'(pass_count), 64'(m_cnt));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule